// File: doc/BRIEF.md
# Adaptive FRC Color Dithering Engine

This block takes 24-bit RGB pixels, 8 bits per channel, and produces 18-bit RGB, 6 bits per channel, for a panel of lower color depth. It uses frame-rate-control dithering. Each channel is first widened to 9 bits and split into a 6-bit base and a 3-bit fraction. A pattern then decides whether the base is raised by one. The pattern depends on the pixel's column parity, its line parity and a 2-bit frame counter. Averaged over space and time, the output therefore tracks the fractional part of the input.

Pixel, line and frame positions come from the incoming timing strobes. The block can follow horizontal and vertical sync pulses, or it can use the data-enable strobe alone. In data-enable-only mode, a long enough inactive gap marks a new frame. Each strobe has its own polarity setting. Several special cases skip the normal pattern: near-black channels, near-full channels and gray pixels. These cases avoid visible flicker at the critical gray levels, and an adaptive-enable input can switch them off. A global enable bypasses dithering and simply truncates the data. All configuration arrives as static inputs.

Top module: `frc_dither_engine`

## Requirements
- R1: Each 8-bit channel value c is widened to the 9-bit value e = {c, c[7]}. The base is t = e[8:3] and the fraction is n = e[2:0].
- R2: Default dithering uses a phase p, which is the frame counter plus the channel index modulo 4 (red is 0, green is 1, blue is 2). The order index is o = {col^line, p[0]^line, p[1]^col}, where col and line are the column and line parities. The output is t+1 when o < n, and t otherwise.
- R3: The increment saturates: an output of 63 is never raised, so the output never wraps to 0.
- R4: When cfg_frc_en is 0, each output channel equals c[7:2].
- R5: With adaptive mode on, a channel with t = 0 outputs 0 on every frame and at every position.
- R6: With adaptive mode on, a channel with t >= 62 outputs t unchanged.
- R7: With adaptive mode on, a gray pixel (r = g = b) that is not covered by R5 or R6 uses phase p = frame counter for all three channels. All three outputs are then identical.
- R8: When cfg_adapt_en is 0, every channel uses the default algorithm of R2 and R3, whatever its value.
- R9: In sync mode (cfg_de_only = 0), a frame start is an active edge of VS and a line start is an active edge of HS. At a frame start the frame counter (which resets to 0) advances by one and the line index becomes 0. Otherwise a line start advances the line index.
- R10: In data-enable-only mode, a line start is an active edge of DE. It is also a frame start only if DE was inactive for more than cfg_blank_thr cycles just before; a gap of exactly cfg_blank_thr cycles is not a frame start.
- R11: For each of HS, VS and DE, a polarity input of 1 means active-high and 0 means active-low.
- R12: The output is registered with a latency of one clock, and hs_o, vs_o and de_o are the raw inputs delayed by one clock. While reset is held, all outputs are 0.
- R13: The column index starts at 0 at each line start and advances after each cycle in which DE is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_frc_en | input | 1 | 1 enables dithering, 0 truncates |
| cfg_adapt_en | input | 1 | 1 enables the special-case algorithms |
| cfg_de_only | input | 1 | 1 selects data-enable-only timing, 0 selects sync timing |
| cfg_hs_pol | input | 1 | HS polarity, 1 is active-high |
| cfg_vs_pol | input | 1 | VS polarity, 1 is active-high |
| cfg_de_pol | input | 1 | DE polarity, 1 is active-high |
| cfg_blank_thr | input | 12 | Inactive-DE gap length that must be exceeded for a frame start |
| pix_r_i | input | 8 | Red input |
| pix_g_i | input | 8 | Green input |
| pix_b_i | input | 8 | Blue input |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| pix_r_o | output | 6 | Red output |
| pix_g_o | output | 6 | Green output |
| pix_b_o | output | 6 | Blue output |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
The hardest situations to reach are the edge of frame detection in data-enable-only mode and the saturating increment. Frame detection depends on an exact gap length. The saturating increment is hidden by the full-on special case whenever adaptive mode is on. The bench sets the gap between lines to exactly the threshold and the vertical blank to one cycle more. A wrong comparison therefore shifts the frame phase and corrupts every following expected pixel. A separate run with adaptive mode off drives values 252 to 255 through all sixteen frame and position phases, so that the saturation path is exercised. Pixel values sweep all 256 codes across varied positions, with gray pixels interleaved. The runs cover both timing modes and inverted polarities.

// File: rtl/frc_pkg.sv
package frc_pkg;

   typedef enum logic [1:0] {
      ALG_DEFAULT  = 2'd0,
      ALG_GRAY     = 2'd1,
      ALG_FULL_OFF = 2'd2,
      ALG_FULL_ON  = 2'd3
   } frc_alg_e;

   typedef struct packed {
      logic [1:0] frame;
      logic       line_par;
      logic       col_par;
   } frc_pos_t;

   // Order index of a pixel-frame position; each value occurs twice in 16 positions
   function automatic logic [2:0] frc_order(input logic [1:0] ph, input logic ln, input logic cl);
      return {cl ^ ln, ph[0] ^ ln, ph[1] ^ cl};
   endfunction

endpackage

// File: rtl/frc_timing.sv
module frc_timing
   import frc_pkg::*;
#(
   parameter int IDLE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_de_only,
   input  logic              cfg_hs_pol,
   input  logic              cfg_vs_pol,
   input  logic              cfg_de_pol,
   input  logic [IDLE_W-1:0] cfg_blank_thr,
   input  logic              hs_i,
   input  logic              vs_i,
   input  logic              de_i,
   output frc_pos_t          pos_o,
   output logic              de_act_o
);

   localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

   logic              hs_a, vs_a, de_a;
   logic              hs_prev_q, vs_prev_q, de_prev_q;
   logic [IDLE_W-1:0] idle_q;
   logic              line_start, frame_start;
   logic              col_par_q, line_par_q;
   logic [1:0]        frame_q;
   frc_pos_t          pos_now;

   assign hs_a = cfg_hs_pol ? hs_i : ~hs_i;
   assign vs_a = cfg_vs_pol ? vs_i : ~vs_i;
   assign de_a = cfg_de_pol ? de_i : ~de_i;

   always_comb begin
      if (cfg_de_only) begin
         line_start  = de_a & ~de_prev_q;
         frame_start = line_start & (idle_q > cfg_blank_thr);
      end else begin
         line_start  = hs_a & ~hs_prev_q;
         frame_start = vs_a & ~vs_prev_q;
      end
   end

   always_comb begin
      pos_now.frame    = frame_q + {1'b0, frame_start};
      pos_now.line_par = frame_start ? 1'b0 : (line_par_q ^ line_start);
      pos_now.col_par  = line_start ? 1'b0 : col_par_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev_q  <= 1'b0;
         vs_prev_q  <= 1'b0;
         de_prev_q  <= 1'b0;
         idle_q     <= '0;
         frame_q    <= '0;
         line_par_q <= 1'b0;
         col_par_q  <= 1'b0;
      end else begin
         hs_prev_q  <= hs_a;
         vs_prev_q  <= vs_a;
         de_prev_q  <= de_a;
         idle_q     <= de_a ? '0 : ((idle_q == IDLE_MAX) ? idle_q : idle_q + 1'b1);
         frame_q    <= pos_now.frame;
         line_par_q <= pos_now.line_par;
         col_par_q  <= pos_now.col_par ^ de_a;
      end
   end

   assign pos_o    = pos_now;
   assign de_act_o = de_a;

   // R9
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> (frame_q == $past(frame_q)));

endmodule

// File: rtl/frc_channel.sv
module frc_channel
   import frc_pkg::*;
#(
   parameter int CH_W   = 8,
   parameter int OUT_W  = 6,
   parameter int CH_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frc_en,
   input  logic             adapt_en,
   input  logic             gray_px,
   input  frc_pos_t         pos,
   input  logic [CH_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   localparam int EXT_W = CH_W + 1;
   localparam int LSB_W = EXT_W - OUT_W;
   localparam int OW1   = OUT_W + 1;
   localparam logic [OUT_W-1:0] FULL      = '1;
   localparam logic [OUT_W-1:0] NEAR_FULL = FULL - 1'b1;
   localparam logic [1:0]       PH_OFS    = 2'(CH_IDX);

   logic [EXT_W-1:0] ext;
   logic [OUT_W-1:0] trunc;
   logic [LSB_W-1:0] frac;
   frc_alg_e         alg;
   logic [1:0]       phase;
   logic [2:0]       ord;
   logic             bump;
   logic [OUT_W-1:0] nxt;

   assign ext   = {din, din[CH_W-1]};
   assign trunc = ext[EXT_W-1 -: OUT_W];
   assign frac  = ext[LSB_W-1:0];

   always_comb begin
      if (adapt_en && trunc == '0)            alg = ALG_FULL_OFF;
      else if (adapt_en && trunc >= NEAR_FULL) alg = ALG_FULL_ON;
      else if (adapt_en && gray_px)           alg = ALG_GRAY;
      else                                    alg = ALG_DEFAULT;
   end

   assign phase = (alg == ALG_GRAY) ? pos.frame : pos.frame + PH_OFS;
   assign ord   = frc_order(phase, pos.line_par, pos.col_par);
   assign bump  = (ord < frac);

   always_comb begin
      unique case (alg)
         ALG_FULL_OFF: nxt = '0;
         ALG_FULL_ON:  nxt = trunc;
         default:      nxt = (bump && trunc != FULL) ? trunc + 1'b1 : trunc;
      endcase
      if (!frc_en) nxt = din[CH_W-1 -: OUT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= nxt;
   end

   // R4
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frc_en |=> (dout == $past(din[CH_W-1 -: OUT_W])));

   // R3
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frc_en |=> (({1'b0, dout} >= {1'b0, $past(trunc)}) &&
                  ({1'b0, dout} <= {1'b0, $past(trunc)} + OW1'(1))));

   // R5
   full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_en && adapt_en && trunc == '0) |=> (dout == '0));

endmodule

// File: rtl/frc_dither_engine.sv
module frc_dither_engine
   import frc_pkg::*;
#(
   parameter int CH_W   = 8,
   parameter int OUT_W  = 6,
   parameter int IDLE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_frc_en,
   input  logic              cfg_adapt_en,
   input  logic              cfg_de_only,
   input  logic              cfg_hs_pol,
   input  logic              cfg_vs_pol,
   input  logic              cfg_de_pol,
   input  logic [IDLE_W-1:0] cfg_blank_thr,
   input  logic [CH_W-1:0]   pix_r_i,
   input  logic [CH_W-1:0]   pix_g_i,
   input  logic [CH_W-1:0]   pix_b_i,
   input  logic              hs_i,
   input  logic              vs_i,
   input  logic              de_i,
   output logic [OUT_W-1:0]  pix_r_o,
   output logic [OUT_W-1:0]  pix_g_o,
   output logic [OUT_W-1:0]  pix_b_o,
   output logic              hs_o,
   output logic              vs_o,
   output logic              de_o
);

   localparam int N_CH = 3;

   if (CH_W + 1 - OUT_W != 3) begin : g_bad_width
      $error("frc_dither_engine: dropped fraction must be exactly 3 bits");
   end
   if (IDLE_W < 2) begin : g_bad_idle
      $error("frc_dither_engine: IDLE_W too small");
   end

   frc_pos_t         pos;
   logic             de_act;
   logic             gray_px;
   logic [CH_W-1:0]  din  [N_CH];
   logic [OUT_W-1:0] dout [N_CH];

   assign din[0]  = pix_r_i;
   assign din[1]  = pix_g_i;
   assign din[2]  = pix_b_i;
   assign gray_px = (pix_r_i == pix_g_i) && (pix_g_i == pix_b_i);

   frc_timing #(.IDLE_W(IDLE_W)) u_timing (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_de_only   (cfg_de_only),
      .cfg_hs_pol    (cfg_hs_pol),
      .cfg_vs_pol    (cfg_vs_pol),
      .cfg_de_pol    (cfg_de_pol),
      .cfg_blank_thr (cfg_blank_thr),
      .hs_i          (hs_i),
      .vs_i          (vs_i),
      .de_i          (de_i),
      .pos_o         (pos),
      .de_act_o      (de_act)
   );

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      frc_channel #(.CH_W(CH_W), .OUT_W(OUT_W), .CH_IDX(k)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .frc_en   (cfg_frc_en),
         .adapt_en (cfg_adapt_en),
         .gray_px  (gray_px),
         .pos      (pos),
         .din      (din[k]),
         .dout     (dout[k])
      );
   end

   assign pix_r_o = dout[0];
   assign pix_g_o = dout[1];
   assign pix_b_o = dout[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_o <= 1'b0;
         vs_o <= 1'b0;
         de_o <= 1'b0;
      end else begin
         hs_o <= hs_i;
         vs_o <= vs_i;
         de_o <= de_i;
      end
   end

   // R7
   gray_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_frc_en && cfg_adapt_en && gray_px && de_act) |=>
         ((pix_r_o == pix_g_o) && (pix_g_o == pix_b_o)));

endmodule

// File: tb/frc_dither_engine_bench.sv
`timescale 1ns/1ps
module frc_dither_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_frc_en = 1'b1, cfg_adapt_en = 1'b1, cfg_de_only = 1'b1;
   logic        cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1, cfg_de_pol = 1'b1;
   logic [11:0] cfg_blank_thr = 12'd6;
   logic [7:0]  pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
   logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
   logic [5:0]  pix_r_o, pix_g_o, pix_b_o;
   logic        hs_o, vs_o, de_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit         exp_valid = 0;
   bit         exp_pix   = 0;
   logic [5:0] exp_r, exp_g, exp_b;
   logic       exp_hs, exp_vs, exp_de;
   string      exp_tag;
   int         pix_cnt = 0;

   localparam int THR = 6;
   localparam int NF  = 16;
   localparam int NL  = 4;
   localparam int W   = 16;

   always #2 clk = ~clk;

   frc_dither_engine u_frc_dither_engine (
      .clk(clk), .rst_n(rst_n), .cfg_frc_en(cfg_frc_en), .cfg_adapt_en(cfg_adapt_en),
      .cfg_de_only(cfg_de_only), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
      .cfg_de_pol(cfg_de_pol), .cfg_blank_thr(cfg_blank_thr),
      .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
      .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
      .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o),
      .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Expected 6-bit output from R1-style arithmetic (widen, split, pattern, saturate)
   function automatic logic [5:0] exp_chan(input logic [7:0] c, input int k, input int f,
                                           input int l, input int col, input bit gray);
      logic [8:0] e;
      int t, n, ph, lp, cp, o;
      e = {c, c[7]};
      t = int'(e[8:3]);
      n = int'(e[2:0]);
      if (!cfg_frc_en) return c[7:2];
      if (cfg_adapt_en && t == 0) return 6'd0;
      if (cfg_adapt_en && t >= 62) return 6'(t);
      ph = (cfg_adapt_en && gray) ? (f % 4) : ((f + k) % 4);
      lp = l % 2;
      cp = col % 2;
      o  = ((cp ^ lp) << 2) | (((ph % 2) ^ lp) << 1) | (((ph / 2) % 2) ^ cp);
      if (o < n) return (t == 63) ? 6'd63 : 6'(t + 1);
      return 6'(t);
   endfunction

   // One clock: check previous cycle's result, then drive this cycle's inputs
   task automatic step(input bit de_a, input bit hs_a, input bit vs_a,
                       input int f, input int l, input int col);
      logic [7:0] r, g, b;
      bit gray;
      @(negedge clk);
      if (exp_valid) begin
         // R12: timing delayed by one clock
         check("R12 hs_o", int'(hs_o), int'(exp_hs));
         check("R12 vs_o", int'(vs_o), int'(exp_vs));
         check("R12 de_o", int'(de_o), int'(exp_de));
         if (exp_pix) begin
            check({exp_tag, " red"},   int'(pix_r_o), int'(exp_r));
            check({exp_tag, " green"}, int'(pix_g_o), int'(exp_g));
            check({exp_tag, " blue"},  int'(pix_b_o), int'(exp_b));
         end
      end
      r = 8'((pix_cnt * 37 + f * 11) & 255);
      g = 8'((pix_cnt * 101 + 3) & 255);
      b = 8'((pix_cnt * 59 + l * 7 + 5) & 255);
      if (pix_cnt % 7 == 3) begin g = r; b = r; end
      if (pix_cnt % 29 == 11) begin r = 8'(252 + (pix_cnt / 29) % 4); end
      gray = (r == g) && (g == b);
      hs_i = cfg_hs_pol ? hs_a : ~hs_a;
      vs_i = cfg_vs_pol ? vs_a : ~vs_a;
      de_i = cfg_de_pol ? de_a : ~de_a;
      pix_r_i = r; pix_g_i = g; pix_b_i = b;
      exp_hs = hs_i; exp_vs = vs_i; exp_de = de_i;
      exp_pix = de_a;
      if (de_a) begin
         exp_r = exp_chan(r, 0, f, l, col, gray);
         exp_g = exp_chan(g, 1, f, l, col, gray);
         exp_b = exp_chan(b, 2, f, l, col, gray);
         pix_cnt++;
      end
      exp_valid = 1;
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n = 1'b0;
      exp_valid = 0;
      hs_i = ~cfg_hs_pol; vs_i = ~cfg_vs_pol; de_i = ~cfg_de_pol;
      pix_r_i = 8'hFF; pix_g_i = 8'hAA; pix_b_i = 8'h55;
      repeat (3) @(negedge clk);
      // R12: reset state
      check({req, " reset red"}, int'(pix_r_o), 0);
      check({req, " reset green"}, int'(pix_g_o), 0);
      check({req, " reset blue"}, int'(pix_b_o), 0);
      check({req, " reset de"}, int'(de_o), 0);
      rst_n = 1'b1;
   endtask

   // R10 / R13: line gap exactly THR (no new frame), vertical blank THR+1 (new frame)
   task automatic run_de_only(input string tag);
      exp_tag = tag;
      for (int fr = 1; fr <= NF; fr++) begin
         for (int i = 0; i < THR + 1; i++) step(0, 0, 0, 0, 0, 0);
         for (int l = 0; l < NL; l++) begin
            if (l > 0) for (int i = 0; i < THR; i++) step(0, 0, 0, 0, 0, 0);
            for (int c = 0; c < W; c++) step(1, 0, 0, fr % 4, l, c);
         end
      end
      step(0, 0, 0, 0, 0, 0);
   endtask

   // R9 / R11: VS and HS edges coincide at frame start, then one HS edge per line
   task automatic run_sync(input string tag);
      exp_tag = tag;
      for (int fr = 1; fr <= NF; fr++) begin
         step(0, 1, 1, 0, 0, 0);
         step(0, 0, 1, 0, 0, 0);
         step(0, 0, 1, 0, 0, 0);
         step(0, 0, 0, 0, 0, 0);
         for (int l = 0; l < NL; l++) begin
            if (l > 0) begin
               step(0, 1, 0, 0, 0, 0);
               step(0, 0, 0, 0, 0, 0);
               step(0, 0, 0, 0, 0, 0);
            end
            for (int c = 0; c < W; c++) step(1, 0, 0, fr % 4, l, c);
         end
      end
      step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      // Run 1: DE-only, adaptive on (R1 R2 R5 R6 R7 R10 R13)
      cfg_de_only = 1; cfg_frc_en = 1; cfg_adapt_en = 1;
      cfg_hs_pol = 1; cfg_vs_pol = 1; cfg_de_pol = 1; cfg_blank_thr = 12'(THR);
      do_reset("R12");
      run_de_only("R2/R5/R6/R7/R10/R13 de-only adaptive");

      // Run 2: adaptive off, saturation reachable (R3 R8)
      cfg_adapt_en = 0;
      do_reset("R12");
      run_de_only("R3/R8 default-only saturation");

      // Run 3: sync mode, all strobes active-low (R9 R11)
      cfg_de_only = 0; cfg_adapt_en = 1;
      cfg_hs_pol = 0; cfg_vs_pol = 0; cfg_de_pol = 0;
      do_reset("R12");
      run_sync("R9/R11 sync inverted");

      // Run 4: bypass with mixed polarity (R4)
      cfg_frc_en = 0; cfg_hs_pol = 1; cfg_vs_pol = 0; cfg_de_pol = 1;
      do_reset("R12");
      run_sync("R4 bypass");

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule